// File: doc/BRIEF.md
# Performance Monitor Counter CSR Bank

This block holds the programmable performance counters of a core together with one event selector per counter. The core's CSR unit drives a 12-bit address, a request strobe, a write enable and write data into the bank. Within the same cycle it gets back read data and an illegal-access flag. Counter slots 3 to 31 are implemented. Slots 0 to 2 belong to the fixed cycle, time and retired-instruction counters that live elsewhere, so the bank never decodes them.

Each counter is 64 bits wide for any XLEN. When XLEN is 32, software reaches the upper half through a separate CSR range. Each slot has an event pulse input, and the counter steps by one while that input is high and the slot's selector is nonzero. A writability mask from outside the bank gates software writes per slot. An enable input turns the whole register set on or off.

Top module: `hpm_csr_bank`

## Requirements
- R1: After reset every counter and every event selector reads zero.
- R2: The event selector of slot i (3 to 31) is at address 0x320+i. It reads and writes all XLEN bits.
- R3: The low counter CSR of slot i is at address 0xB00+i. A read returns counter bits XLEN-1..0, and a write replaces exactly those bits.
- R4: When XLEN is 32, the high counter CSR of slot i is at address 0xB80+i. A read returns counter bits 63..32, and a write replaces exactly those bits.
- R5: A write to any CSR of slot i takes effect only when bit i of the writability mask is 1. Otherwise the write is dropped with no flag.
- R6: A request whose address bits 4..0 are 0, 1 or 2 asserts the illegal flag, reads zero and changes no state.
- R7: While the enable input is low, every request is illegal, reads zero and changes no state.
- R8: A request outside the selector, low and (for XLEN 32) high ranges is illegal and reads zero. No flag is raised when no request is made.
- R9: A counter adds one at a clock edge when its event input is high and its selector is nonzero. A zero selector holds the counter.
- R10: When a write to a slot's counter (either half) and an increment fall in the same cycle, the written value is stored and the increment is lost.
- R11: Counting is 64-bit. A carry out of bit 31 propagates into the high half.
- R12: Read data and the illegal flag depend combinationally on the current request. An illegal request always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hpm_en_i | input | 1 | Counter register set enabled |
| csr_req_i | input | 1 | CSR access this cycle |
| csr_we_i | input | 1 | Access is a write |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data |
| csr_illegal_o | output | 1 | Access is not defined |
| wr_mask_i | input | 32 | Per-slot write permission |
| event_i | input | 32 | Per-slot event pulses |

## Verification
A software write and an event increment can hit the same counter in the same cycle. A selector write can also coincide with an event on that slot. In that case the increment still uses the old selector value. The random phase keeps events high on many slots while it writes random addresses, so these collisions occur often. A bench model applies the write-wins rule and the old-selector rule, and every read is compared against it. Directed cases force a write and an event onto one slot in the same cycle, and they also push the low half across a carry while the slot is counting.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
  localparam int unsigned SLOT_NUM   = 32;
  localparam int unsigned IDX_W      = $clog2(SLOT_NUM);
  localparam int unsigned FIRST_SLOT = 3;
  localparam int unsigned CTR_W      = 64;
  localparam int unsigned HALF_W     = CTR_W / 2;
  localparam int unsigned ADDR_W     = 12;

  localparam logic [ADDR_W-1:0] EV_BASE = 12'h320;
  localparam logic [ADDR_W-1:0] LO_BASE = 12'hB00;
  localparam logic [ADDR_W-1:0] HI_BASE = 12'hB80;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_EV   = 2'd1,
    KIND_LO   = 2'd2,
    KIND_HI   = 2'd3
  } csr_kind_e;

  typedef struct packed {
    logic             legal;
    csr_kind_e        kind;
    logic [IDX_W-1:0] idx;
  } hpm_dec_t;
endpackage

// File: rtl/hpm_csr_decode.sv
module hpm_csr_decode
  import hpm_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output hpm_dec_t          dec_o
);
  localparam int unsigned PAGE_W = ADDR_W - IDX_W;

  logic [PAGE_W-1:0] page;
  logic [IDX_W-1:0]  idx;
  logic              in_ev, in_lo, in_hi, slot_ok;

  assign page    = addr_i[ADDR_W-1:IDX_W];
  assign idx     = addr_i[IDX_W-1:0];
  assign in_ev   = page == EV_BASE[ADDR_W-1:IDX_W];
  assign in_lo   = page == LO_BASE[ADDR_W-1:IDX_W];
  assign in_hi   = (XLEN == 32) && (page == HI_BASE[ADDR_W-1:IDX_W]);
  assign slot_ok = idx >= IDX_W'(FIRST_SLOT);

  always_comb begin
    dec_o.idx = idx;
    if (in_ev)      dec_o.kind = KIND_EV;
    else if (in_lo) dec_o.kind = KIND_LO;
    else if (in_hi) dec_o.kind = KIND_HI;
    else            dec_o.kind = KIND_NONE;
    dec_o.legal = en_i && slot_ok && (in_ev || in_lo || in_hi);
  end
endmodule

// File: rtl/hpm_ctr_slot.sv
module hpm_ctr_slot
  import hpm_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic             wr_ev_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic             event_i,
  output logic [CTR_W-1:0] cnt_o,
  output logic [XLEN-1:0]  evsel_o
);
  logic [CTR_W-1:0] cnt_q, cnt_wr;
  logic [XLEN-1:0]  evsel_q;
  logic             count_en;

  assign count_en = event_i && (evsel_q != '0);

  always_comb begin
    cnt_wr = cnt_q;
    if (wr_lo_i) cnt_wr[XLEN-1:0]     = wdata_i;
    if (wr_hi_i) cnt_wr[CTR_W-1:HALF_W] = wdata_i[HALF_W-1:0];
  end

  // software write beats the event increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (wr_lo_i || wr_hi_i) cnt_q <= cnt_wr;
    else if (count_en)          cnt_q <= cnt_q + CTR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      evsel_q <= '0;
    else if (wr_ev_i) evsel_q <= wdata_i;
  end

  assign cnt_o   = cnt_q;
  assign evsel_o = evsel_q;
endmodule

// File: rtl/hpm_rd_mux.sv
module hpm_rd_mux
  import hpm_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  hpm_dec_t                          dec_i,
  input  logic [SLOT_NUM-1:0][CTR_W-1:0]    cnt_i,
  input  logic [SLOT_NUM-1:0][XLEN-1:0]     evsel_i,
  output logic [XLEN-1:0]                   rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (dec_i.legal) begin
      unique case (dec_i.kind)
        KIND_EV: rdata_o = evsel_i[dec_i.idx];
        KIND_LO: rdata_o = cnt_i[dec_i.idx][XLEN-1:0];
        KIND_HI: rdata_o = XLEN'(cnt_i[dec_i.idx][CTR_W-1:HALF_W]);
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/hpm_csr_bank.sv
module hpm_csr_bank
  import hpm_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hpm_en_i,
  input  logic                csr_req_i,
  input  logic                csr_we_i,
  input  logic [ADDR_W-1:0]   csr_addr_i,
  input  logic [XLEN-1:0]     csr_wdata_i,
  output logic [XLEN-1:0]     csr_rdata_o,
  output logic                csr_illegal_o,
  input  logic [SLOT_NUM-1:0] wr_mask_i,
  input  logic [SLOT_NUM-1:0] event_i
);
  hpm_dec_t                       dec;
  logic                           wr_go;
  logic [SLOT_NUM-1:0][CTR_W-1:0] cnt_q;
  logic [SLOT_NUM-1:0][XLEN-1:0]  ev_q;
  logic [SLOT_NUM-1:0]            wr_any;
  logic                           unused_low_slots;

  hpm_csr_decode #(.XLEN(XLEN)) u_dec (
    .en_i   (hpm_en_i),
    .addr_i (csr_addr_i),
    .dec_o  (dec)
  );

  assign wr_go         = csr_req_i && csr_we_i && dec.legal;
  assign csr_illegal_o = csr_req_i && !dec.legal;

  for (genvar i = 0; i < SLOT_NUM; i++) begin : g_slot
    if (i < FIRST_SLOT) begin : g_rsvd
      assign cnt_q[i]  = '0;
      assign ev_q[i]   = '0;
      assign wr_any[i] = 1'b0;
    end else begin : g_ctr
      logic sel, wr_lo, wr_hi, wr_ev;
      assign sel    = wr_go && (dec.idx == IDX_W'(i)) && wr_mask_i[i];
      assign wr_lo  = sel && (dec.kind == KIND_LO);
      assign wr_hi  = sel && (dec.kind == KIND_HI);
      assign wr_ev  = sel && (dec.kind == KIND_EV);
      assign wr_any[i] = wr_lo || wr_hi;

      hpm_ctr_slot #(.XLEN(XLEN)) u_slot (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_lo_i (wr_lo),
        .wr_hi_i (wr_hi),
        .wr_ev_i (wr_ev),
        .wdata_i (csr_wdata_i),
        .event_i (event_i[i]),
        .cnt_o   (cnt_q[i]),
        .evsel_o (ev_q[i])
      );
    end
  end

  assign unused_low_slots = ^{wr_mask_i[FIRST_SLOT-1:0], event_i[FIRST_SLOT-1:0]};

  hpm_rd_mux #(.XLEN(XLEN)) u_rd (
    .dec_i   (dec),
    .cnt_i   (cnt_q),
    .evsel_i (ev_q),
    .rdata_o (csr_rdata_o)
  );
endmodule

// File: rtl/hpm_csr_bank_chk.sv
module hpm_csr_bank_chk
  import hpm_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           hpm_en_i,
  input logic                           csr_req_i,
  input logic [ADDR_W-1:0]              csr_addr_i,
  input logic [XLEN-1:0]                csr_rdata_o,
  input logic                           csr_illegal_o,
  input logic [SLOT_NUM-1:0]            wr_mask_i,
  input logic [SLOT_NUM-1:0]            event_i,
  input logic [SLOT_NUM-1:0][CTR_W-1:0] cnt_q,
  input logic [SLOT_NUM-1:0][XLEN-1:0]  ev_q,
  input logic [SLOT_NUM-1:0]            wr_any
);
  AST_ILLEGAL_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o |-> csr_rdata_o == '0); // R12
  AST_DISABLED_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_req_i && !hpm_en_i) |-> csr_illegal_o); // R7
  AST_RSVD_SLOT_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_req_i && csr_addr_i[IDX_W-1:0] < IDX_W'(FIRST_SLOT)) |-> csr_illegal_o); // R6
  AST_NO_REQ_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_req_i |-> !csr_illegal_o); // R8

  for (genvar i = FIRST_SLOT; i < SLOT_NUM; i++) begin : g_chk
    AST_MASKED_EVSEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_mask_i[i] |=> ev_q[i] == $past(ev_q[i])); // R5
    AST_EVENT_INCREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_any[i] && event_i[i] && ev_q[i] != '0) |=> cnt_q[i] == $past(cnt_q[i]) + CTR_W'(1)); // R9
    AST_IDLE_SELECTOR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_any[i] && ev_q[i] == '0) |=> $stable(cnt_q[i])); // R9
  end
endmodule

bind hpm_csr_bank hpm_csr_bank_chk #(.XLEN(XLEN)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .hpm_en_i      (hpm_en_i),
  .csr_req_i     (csr_req_i),
  .csr_addr_i    (csr_addr_i),
  .csr_rdata_o   (csr_rdata_o),
  .csr_illegal_o (csr_illegal_o),
  .wr_mask_i     (wr_mask_i),
  .event_i       (event_i),
  .cnt_q         (cnt_q),
  .ev_q          (ev_q),
  .wr_any        (wr_any)
);

// File: tb/hpm_csr_bank_bench.sv
module hpm_csr_bank_bench;
  localparam int XLEN = 32;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            hpm_en_i = 1'b1;
  logic            csr_req_i = 1'b0;
  logic            csr_we_i = 1'b0;
  logic [11:0]     csr_addr_i = '0;
  logic [XLEN-1:0] csr_wdata_i = '0;
  logic [XLEN-1:0] csr_rdata_o;
  logic            csr_illegal_o;
  logic [31:0]     wr_mask_i = '1;
  logic [31:0]     event_i = '0;

  int checks = 0;
  int failures = 0;
  logic [63:0]     m_cnt [32];
  logic [XLEN-1:0] m_ev  [32];

  always #10 clk_i = ~clk_i;

  hpm_csr_bank #(.XLEN(XLEN)) u_hpm_csr_bank (.*);

  // 0 none, 1 selector, 2 low, 3 high
  function automatic int kind_of(logic [11:0] a);
    if (a[11:5] == 7'h19) return 1;
    if (a[11:5] == 7'h58) return 2;
    if (a[11:5] == 7'h5C && XLEN == 32) return 3;
    return 0;
  endfunction

  function automatic logic legal_of(logic en, logic [11:0] a);
    return en && a[4:0] >= 3 && kind_of(a) != 0;
  endfunction

  function automatic logic [XLEN-1:0] read_of(logic en, logic [11:0] a);
    int k = kind_of(a);
    if (!legal_of(en, a)) return '0;
    if (k == 1) return m_ev[a[4:0]];
    if (k == 2) return m_cnt[a[4:0]][XLEN-1:0];
    return XLEN'(m_cnt[a[4:0]][63:32]);
  endfunction

  function automatic string tag_of(logic en, logic [11:0] a);
    int k = kind_of(a);
    if (!en) return "R7";
    if (k == 0) return "R8";
    if (a[4:0] < 3) return "R6";
    if (k == 1) return "R2";
    if (k == 2) return "R3";
    return "R4";
  endfunction

  task automatic step(input logic en, input logic req, input logic we, input logic [11:0] a,
                      input logic [XLEN-1:0] wd, input logic [31:0] mask,
                      input logic [31:0] ev, input string tag);
    string t;
    logic [XLEN-1:0] exp_rd;
    logic exp_ill;
    @(negedge clk_i);
    hpm_en_i = en; csr_req_i = req; csr_we_i = we; csr_addr_i = a;
    csr_wdata_i = wd; wr_mask_i = mask; event_i = ev;
    #2;
    t = (tag == "") ? tag_of(en, a) : tag;
    exp_ill = req && !legal_of(en, a);
    checks++;
    if (csr_illegal_o !== exp_ill) begin
      failures++;
      $display("FAIL %s illegal addr=%h actual=%b expected=%b", t, a, csr_illegal_o, exp_ill);
    end
    if (req) begin
      exp_rd = read_of(en, a);
      checks++;
      if (csr_rdata_o !== exp_rd) begin
        failures++;
        $display("FAIL %s rdata addr=%h actual=%h expected=%h", t, a, csr_rdata_o, exp_rd);
      end
    end
    // model the coming edge: increments use the old selector, writes win
    for (int i = 3; i < 32; i++) begin
      logic w = req && we && legal_of(en, a) && a[4:0] == 5'(i) && mask[i];
      int k = kind_of(a);
      if (w && k == 2) m_cnt[i][XLEN-1:0] = wd;
      else if (w && k == 3) m_cnt[i][63:32] = wd[31:0];
      else if (ev[i] && m_ev[i] != '0) m_cnt[i] = m_cnt[i] + 64'd1;
      if (w && k == 1) m_ev[i] = wd;
    end
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    step(1'b1, 1'b1, 1'b0, a, '0, '1, '0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [XLEN-1:0] d, input string tag);
    step(1'b1, 1'b1, 1'b1, a, d, '1, '0, tag);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin m_cnt[i] = '0; m_ev[i] = '0; end
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: everything zero after reset
    for (int i = 3; i < 32; i++) begin
      rd(12'h320 + 12'(i), "R1");
      rd(12'hB00 + 12'(i), "R1");
      rd(12'hB80 + 12'(i), "R1");
    end

    // R2, R3, R4 basic access
    wr(12'h323, 32'hDEAD_BEEF, "R2");
    rd(12'h323, "R2");
    wr(12'hB1D, 32'h1234_5678, "R3");
    wr(12'hB9D, 32'h0000_00AB, "R4");
    rd(12'hB1D, "R3");
    rd(12'hB9D, "R4");

    // R5: masked writes dropped
    step(1'b1, 1'b1, 1'b1, 12'h329, 32'h5555, ~(32'h1 << 9), '0, "R5");
    rd(12'h329, "R5");
    step(1'b1, 1'b1, 1'b1, 12'hB09, 32'h77, ~(32'h1 << 9), '0, "R5");
    rd(12'hB09, "R5");

    // R6: reserved slots
    step(1'b1, 1'b1, 1'b1, 12'h320, 32'h1, '1, '0, "R6");
    step(1'b1, 1'b1, 1'b1, 12'hB02, 32'h1, '1, '0, "R6");
    rd(12'h323, "R6");

    // R7: disabled
    step(1'b0, 1'b1, 1'b1, 12'h323, 32'h99, '1, '0, "R7");
    rd(12'h323, "R7");

    // R8: outside ranges, no request
    rd(12'h300, "R8");
    step(1'b1, 1'b0, 1'b0, 12'h300, '0, '1, '0, "R8");

    // R9: count with nonzero selector, hold with zero
    wr(12'h324, 32'h1, "R9");
    step(1'b1, 1'b1, 1'b0, 12'hB04, '0, '1, 32'h30, "R9");
    step(1'b1, 1'b1, 1'b0, 12'hB04, '0, '1, 32'h30, "R9");
    rd(12'hB04, "R9");
    rd(12'hB05, "R9");

    // R10: write and event same cycle
    step(1'b1, 1'b1, 1'b1, 12'hB04, 32'h100, '1, 32'h10, "R10");
    rd(12'hB04, "R10");
    step(1'b1, 1'b1, 1'b1, 12'hB84, 32'h7, '1, 32'h10, "R10");
    rd(12'hB04, "R10");
    rd(12'hB84, "R10");

    // R11: carry into high half
    wr(12'h327, 32'h2, "R11");
    wr(12'hB07, 32'hFFFF_FFFF, "R11");
    step(1'b1, 1'b1, 1'b0, 12'hB87, '0, '1, 32'h80, "R11");
    rd(12'hB87, "R11");
    rd(12'hB07, "R11");

    // random mix, R12 on every read
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] a;
      int sel = $urandom_range(0, 9);
      a[4:0] = 5'($urandom_range(0, 31));
      case (sel)
        0, 1, 2: a[11:5] = 7'h19;
        3, 4, 5: a[11:5] = 7'h58;
        6, 7, 8: a[11:5] = 7'h5C;
        default: a[11:5] = 7'($urandom);
      endcase
      step($urandom_range(0, 15) != 0, $urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1, a,
           ($urandom_range(0, 3) == 0) ? '0 : XLEN'($urandom),
           $urandom | $urandom, $urandom | $urandom, "");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule